// File: doc/BRIEF.md
# March C- Memory Test Sequencer

This block runs the six-element March C- algorithm on a bit-oriented SRAM that has `ROWS` rows and `COLS` columns, and checks what the memory returns. After a start pulse it issues one memory operation every clock. It drives the row and column address, a write enable with write data, and a read strobe with the value the read should return. Inside every element the sequencer finishes all the columns of one row before it moves to the next row, so the column is always the fastest-changing index. In descending elements both the row order and the column order run backwards, which gives the two ends of a row mirrored stress.

The SRAM returns read data one clock after the read strobe. The sequencer compares that data with the registered expected value. On the first mismatch it records where the fault was found and keeps running to the end of the test. A per-row marker tells the bit-line precharge logic when the last operation of a row is being issued, so the bit lines can be fully restored before the next row starts.

Top module: `marchc_seq`

## Requirements
- R1: After reset and before any start pulse, `wrEn`, `rdEn`, `rowLast`, `done` and `fail` are all 0.
- R2: A test runs six elements in a fixed order. Each element is listed as (index: direction, operations): 0: ascending, w0; 1: ascending, r0 then w1; 2: ascending, r1 then w0; 3: descending, r0 then w1; 4: descending, r1 then w0; 5: ascending, r0. This gives 10 operations per cell, 10·ROWS·COLS in total.
- R3: Ascending elements start at row 0, column 0. The column increments up to COLS-1, then the row increments and the column returns to 0.
- R4: Descending elements start at row ROWS-1, column COLS-1. The column decrements to 0, then the row decrements and the column returns to COLS-1.
- R5: In a two-operation element, the read and the write to a cell are issued in consecutive cycles to the same address, before the column changes.
- R6: `rowLast` is 1 exactly when the last operation on the last-visited cell of a row is issued. That cell is column COLS-1 when ascending and column 0 when descending.
- R7: While running, exactly one of `wrEn` and `rdEn` is 1 in every cycle. For a write, `wrData` carries the value; for a read, `expData` carries the expected value.
- R8: `rdData` is compared one cycle after the read strobe. On the first mismatch the block captures the element index (0..5), row, column and the observed bit into `failElem`, `failRow`, `failCol` and `failData`.
- R9: `fail` is sticky for the rest of the test. Later mismatches do not change the captured fields, and the test still runs through all six elements.
- R10: `done` is a one-cycle pulse two cycles after the final read of element 5 is issued. At that point `fail` and the captured fields are final.
- R11: A start pulse while a test is running has no effect. A start pulse while idle begins a new test and clears `fail` and the captured fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a test when the block is idle |
| rdData | input | 1 | SRAM read data, valid one cycle after `rdEn` |
| rowAddr | output | clog2(ROWS) | Row address |
| colAddr | output | clog2(COLS) | Column address |
| wrEn | output | 1 | Write strobe |
| wrData | output | 1 | Write value |
| rdEn | output | 1 | Read strobe |
| expData | output | 1 | Expected read value |
| rowLast | output | 1 | Last operation of the current row |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| failElem | output | 3 | Element index of the first mismatch |
| failRow | output | clog2(ROWS) | Row of the first mismatch |
| failCol | output | clog2(COLS) | Column of the first mismatch |
| failData | output | 1 | Bit observed at the first mismatch |

## Verification
The assertions assume that the SRAM always returns read data exactly one cycle after `rdEn`. They also assume that `start` is a clean synchronous level. The bench meets both conditions: its memory model registers read data on the same edge that samples the strobe, and it changes `start` only on falling edges. Stuck-at faults are injected at chosen cells so that mismatches occur in several elements, which exercises first-failure capture. A start pulse is also applied in the middle of a run to show that it is ignored.

// File: rtl/marchc_pkg.sv
package marchc_pkg;
  typedef logic [2:0] elemT;

  localparam elemT FINAL_ELEM = 3'd5;

  typedef struct packed {
    logic rdIssue;
    logic expVal;
    elemT elem;
    logic finalOp;
    logic clear;
  } strobeT;

  // Elements 1 to 4 apply a read and then a write to every cell.
  function automatic logic pairElem(elemT e);
    return (e == 3'd1) || (e == 3'd2) || (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic logic downElem(elemT e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic logic isWriteOp(elemT e, logic op);
    if (e == 3'd0) return 1'b1;
    if (e == FINAL_ELEM) return 1'b0;
    return op;
  endfunction

  function automatic logic opValue(elemT e, logic op);
    if ((e == 3'd1) || (e == 3'd3)) return op;
    if ((e == 3'd2) || (e == 3'd4)) return ~op;
    return 1'b0;
  endfunction
endpackage

// File: rtl/marchc_ctrl.sv
module marchc_ctrl
  import marchc_pkg::*;
#(
  parameter int ROWS = 512,
  parameter int COLS = 512,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic [RW-1:0] rowAddr,
  output logic [CW-1:0] colAddr,
  output logic          wrEn,
  output logic          wrData,
  output logic          rdEn,
  output logic          expData,
  output logic          rowLast,
  output strobeT        strb
);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

  logic          running;
  elemT          elem;
  logic          op;
  logic [RW-1:0] row;
  logic [CW-1:0] col;

  logic desc, cellDone, colEnd, rowEnd, writeNow, value;
  elemT nextElem;

  always_comb begin
    desc     = downElem(elem);
    cellDone = pairElem(elem) ? op : 1'b1;
    colEnd   = desc ? (col == '0) : (col == COL_MAX);
    rowEnd   = desc ? (row == '0) : (row == ROW_MAX);
    writeNow = isWriteOp(elem, op);
    value    = opValue(elem, op);
    nextElem = elemT'(elem + 3'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      elem    <= '0;
      op      <= 1'b0;
      row     <= '0;
      col     <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        elem    <= '0;
        op      <= 1'b0;
        row     <= '0;
        col     <= '0;
      end
    end else if (!cellDone) begin
      op <= 1'b1;
    end else begin
      op <= 1'b0;
      if (!colEnd) begin
        col <= desc ? col - 1'b1 : col + 1'b1;
      end else if (!rowEnd) begin
        col <= desc ? COL_MAX : '0;
        row <= desc ? row - 1'b1 : row + 1'b1;
      end else if (elem == FINAL_ELEM) begin
        running <= 1'b0;
        elem    <= '0;
        row     <= '0;
        col     <= '0;
      end else begin
        elem <= nextElem;
        row  <= downElem(nextElem) ? ROW_MAX : '0;
        col  <= downElem(nextElem) ? COL_MAX : '0;
      end
    end
  end

  always_comb begin
    rowAddr      = row;
    colAddr      = col;
    wrEn         = running & writeNow;
    rdEn         = running & ~writeNow;
    wrData       = value;
    expData      = value;
    rowLast      = running & cellDone & colEnd;
    strb.rdIssue = running & ~writeNow;
    strb.expVal  = value;
    strb.elem    = elem;
    strb.finalOp = running & cellDone & colEnd & rowEnd & (elem == FINAL_ELEM);
    strb.clear   = ~running & start;
  end

  // R7: never a read and a write in the same cycle
  a_r7_single_op: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !rdEn);

  // R3 R4: addresses stay inside the array
  a_r3_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || rdEn) |-> (rowAddr <= ROW_MAX && colAddr <= COL_MAX));

  // R6: the row marker only appears at an end column
  a_r6_rowlast_edge: assert property (@(posedge clk) disable iff (!rstN)
    rowLast |-> (colAddr == '0 || colAddr == COL_MAX));

  // R5: the read of a pair is followed by the write to the same cell
  a_r5_pair_same_cell: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && pairElem(elem)) |=> (wrEn && $stable(rowAddr) && $stable(colAddr)));
endmodule

// File: rtl/marchc_check.sv
module marchc_check
  import marchc_pkg::*;
#(
  parameter int RW = 9,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic [RW-1:0] rowIn,
  input  logic [CW-1:0] colIn,
  input  logic          rdData,
  output logic          done,
  output logic          fail,
  output elemT          failElem,
  output logic [RW-1:0] failRow,
  output logic [CW-1:0] failCol,
  output logic          failData
);
  logic          pendRd, pendExp, pendFinal;
  elemT          pendElem;
  logic [RW-1:0] pendRow;
  logic [CW-1:0] pendCol;
  logic          mismatch;

  assign mismatch = pendRd & (rdData != pendExp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendRd    <= 1'b0;
      pendExp   <= 1'b0;
      pendFinal <= 1'b0;
      pendElem  <= '0;
      pendRow   <= '0;
      pendCol   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      failElem  <= '0;
      failRow   <= '0;
      failCol   <= '0;
      failData  <= 1'b0;
    end else begin
      pendRd    <= strb.rdIssue;
      pendExp   <= strb.expVal;
      pendFinal <= strb.finalOp;
      pendElem  <= strb.elem;
      pendRow   <= rowIn;
      pendCol   <= colIn;
      done      <= pendFinal;
      if (strb.clear) begin
        fail     <= 1'b0;
        failElem <= '0;
        failRow  <= '0;
        failCol  <= '0;
        failData <= 1'b0;
      end else if (mismatch && !fail) begin
        fail     <= 1'b1;
        failElem <= pendElem;
        failRow  <= pendRow;
        failCol  <= pendCol;
        failData <= rdData;
      end
    end
  end

  // R9: fail stays set until a new test is started
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strb.clear) |=> fail);

  // R9: captured fields do not change once fail is set
  a_r9_capture_held: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strb.clear) |=> ($stable(failElem) && $stable(failRow) && $stable(failCol)));

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: a capture only ever records a real element index
  a_r8_elem_range: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (failElem <= FINAL_ELEM));
endmodule

// File: rtl/marchc_seq.sv
module marchc_seq
  import marchc_pkg::*;
#(
  parameter int ROWS = 512,
  parameter int COLS = 512,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          rdData,
  output logic [RW-1:0] rowAddr,
  output logic [CW-1:0] colAddr,
  output logic          wrEn,
  output logic          wrData,
  output logic          rdEn,
  output logic          expData,
  output logic          rowLast,
  output logic          done,
  output logic          fail,
  output logic [2:0]    failElem,
  output logic [RW-1:0] failRow,
  output logic [CW-1:0] failCol,
  output logic          failData
);
  strobeT strb;

  marchc_ctrl #(.ROWS(ROWS), .COLS(COLS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .rowAddr(rowAddr), .colAddr(colAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .expData(expData),
    .rowLast(rowLast), .strb(strb)
  );

  marchc_check #(.RW(RW), .CW(CW)) uCheck (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rowIn(rowAddr), .colIn(colAddr), .rdData(rdData),
    .done(done), .fail(fail), .failElem(failElem),
    .failRow(failRow), .failCol(failCol), .failData(failData)
  );
endmodule

// File: tb/sim_marchc_seq.sv
`timescale 1ns/1ps
module sim_marchc_seq;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int RW = 2;
  localparam int CW = 3;

  // vector: {faultOn, stuckVal, row[1:0], col[2:0], firstElem[2:0]}
  localparam int NV = 5;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 3'd0, 3'd0},
    {1'b1, 1'b0, 2'd0, 3'd0, 3'd2},
    {1'b1, 1'b1, 2'd3, 3'd7, 3'd1},
    {1'b1, 1'b0, 2'd2, 3'd5, 3'd2},
    {1'b1, 1'b1, 2'd1, 3'd0, 3'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rdData;
  logic [RW-1:0] rowAddr, failRow;
  logic [CW-1:0] colAddr, failCol;
  logic wrEn, wrData, rdEn, expData, rowLast, done, fail, failData;
  logic [2:0] failElem;

  int checks = 0;
  int failures = 0;

  logic mem [ROWS*COLS];
  logic rdQ = 1'b0;
  logic faultOn = 1'b0;
  logic stuckVal = 1'b0;
  int faultRow = 0;
  int faultCol = 0;

  always #2.5 clk = ~clk;

  marchc_seq #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .rdData(rdData),
    .rowAddr(rowAddr), .colAddr(colAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .expData(expData), .rowLast(rowLast), .done(done),
    .fail(fail), .failElem(failElem), .failRow(failRow), .failCol(failCol),
    .failData(failData)
  );

  always_ff @(posedge clk) begin
    if (wrEn) mem[int'(rowAddr)*COLS + int'(colAddr)] <= wrData;
    if (rdEn) begin
      if (faultOn && int'(rowAddr) == faultRow && int'(colAddr) == faultCol)
        rdQ <= stuckVal;
      else
        rdQ <= mem[int'(rowAddr)*COLS + int'(colAddr)];
    end
  end
  assign rdData = rdQ;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Walks one full test from the first issued operation; pokeAt >= 0 pulses start mid-run.
  task automatic walk(input int pokeAt);
    int idx = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int e = 0; e < 6; e++) begin
      int nOps = (e == 0 || e == 5) ? 1 : 2;
      bit desc = (e == 3 || e == 4);
      for (int ri = 0; ri < ROWS; ri++) begin
        for (int ci = 0; ci < COLS; ci++) begin
          for (int o = 0; o < nOps; o++) begin
            int r = desc ? ROWS-1-ri : ri;
            int c = desc ? COLS-1-ci : ci;
            bit w = (e == 0) ? 1'b1 : (e == 5) ? 1'b0 : bit'(o);
            bit d = (e == 0 || e == 5) ? 1'b0 : (e == 1 || e == 3) ? bit'(o) : !bit'(o);
            bit last = (o == nOps-1) && (desc ? (c == 0) : (c == COLS-1));
            // R2 R3 R4 R5 R7: order, address and operation kind
            chk(wrEn == w && rdEn == !w && int'(rowAddr) == r && int'(colAddr) == c,
                "R2/R3/R4/R5 op", {int'(wrEn), int'(rowAddr), int'(colAddr)}, {int'(w), r, c});
            chk((w ? wrData : expData) == d, "R7 data", int'(w ? wrData : expData), int'(d));
            chk(rowLast == last, "R6 rowLast", int'(rowLast), int'(last));
            start = (idx == pokeAt); // R11 mid-run start ignored
            idx++;
            @(negedge clk);
          end
        end
      end
    end
    start = 1'b0;
    chk(!done && !wrEn && !rdEn, "R10 done early", int'(done), 0);
    @(negedge clk);
    chk(done, "R10 done pulse", int'(done), 1);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL R10 watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #12 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!wrEn && !rdEn && !rowLast && !done && !fail, "R1 reset idle",
        {int'(wrEn), int'(rdEn), int'(rowLast), int'(done), int'(fail)}, 0);

    for (int v = 0; v < NV; v++) begin
      faultOn  = VEC[v][9];
      stuckVal = VEC[v][8];
      faultRow = int'(VEC[v][7:6]);
      faultCol = int'(VEC[v][5:3]);
      walk((v == 0) ? 40 : -1);
      // R8 R9 first-failure capture and sticky flag, all elements ran
      chk(fail == faultOn, "R9 fail flag", int'(fail), int'(faultOn));
      if (faultOn) begin
        chk(int'(failElem) == int'(VEC[v][2:0]), "R8 failElem", int'(failElem), int'(VEC[v][2:0]));
        chk(int'(failRow) == faultRow && int'(failCol) == faultCol, "R8 failAddr",
            int'(failRow)*COLS + int'(failCol), faultRow*COLS + faultCol);
        chk(failData == stuckVal, "R8 failData", int'(failData), int'(stuckVal));
      end
      @(negedge clk);
      chk(!done, "R10 single cycle", int'(done), 0);
    end

    // R11: a fresh start clears a previous failure
    faultOn = 1'b1; stuckVal = 1'b1; faultRow = 2; faultCol = 3;
    walk(-1);
    chk(fail && failElem == 3'd1, "R11 fault run", int'(failElem), 1);
    faultOn = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!fail && failElem == 3'd0, "R11 clear on start", int'(fail), 0);
    repeat (ROWS*COLS*10 + 4) @(negedge clk);
    chk(!fail && !wrEn && !rdEn, "R11 clean rerun", int'(fail), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule